// File: doc/BRIEF.md
# Register Alias Table Renamer

This block keeps, for every architectural register of an out-of-order core, a pointer to where the newest value of that register lives. The value is either in a reorder-buffer (ROB) entry that holds a speculative result, or in the retirement register file (RRF) that holds committed state. Each cycle a group of up to four micro-ops arrives. Every micro-op that writes a register gets the next ROB entry number as its destination tag. Each source operand is looked up in the table, and a register produced by an older micro-op in the same group is forwarded from that micro-op instead.

There is no free list of physical registers: a destination tag is simply the ROB slot number. When the ROB retires an entry, the table entry for that register goes back to the RRF, but only if the table still points at that ROB slot. A flush puts every register back on the RRF. If the ROB cannot take every destination of the group, the whole group waits.

The outputs of a cycle are combinational. They are computed from the table contents at the start of the cycle, after that cycle's retirements have been applied, and from the group inputs. The table itself updates at the next clock edge.

Top module: `rat_renamer`

## Requirements
- R1: After reset every architectural register reads as RRF-resident (the source ROB flag is 0).
- R2: Destination tags count up from `rob_tail_i` in slot order, wrapping modulo the ROB depth. Only valid slots with `slot_wr_i` set take a tag, and those slots are tagged whether or not the group is accepted.
- R3: A source with no older in-group writer returns the table mapping: the ROB flag plus the tag.
- R4: A source that matches the destination of an older valid writer in the same group returns the tag of the youngest such writer, with the ROB flag at 1.
- R5: When several micro-ops of an accepted group write one register, the table keeps the tag of the youngest of them.
- R6: A retirement (register, tag) clears the register's ROB flag only if the table currently maps that register to that tag. Otherwise the mapping is left unchanged.
- R7: A retirement that clears a mapping is already visible to the sources renamed in the same cycle. A rename that writes the same register in that cycle wins over the clear.
- R8: When the number of destinations in the group exceeds `rob_free_i`, `grp_stall_o` is 1, `grp_fire_o` is 0 and the table takes no rename update. Otherwise a group with at least one valid slot fires.
- R9: `flush_i` forces `grp_fire_o` to 0 and, from the next cycle on, every register reads as RRF-resident.
- R10: A slot with `slot_vld_i` at 0 takes no tag, shifts no other slot's tag and does not change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Revert every mapping to the RRF; blocks renaming this cycle |
| slot_vld_i | input | GROUP | Slot holds a micro-op (bit g = slot g, slot 0 oldest) |
| slot_wr_i | input | GROUP | Slot writes a destination register |
| slot_dst_i | input | GROUP*AREG_W | Destination register index per slot |
| slot_srca_i | input | GROUP*AREG_W | First source register index per slot |
| slot_srcb_i | input | GROUP*AREG_W | Second source register index per slot |
| rob_tail_i | input | TAG_W | Next free ROB entry number |
| rob_free_i | input | FREE_W | Number of free ROB entries |
| ret_vld_i | input | RET_PORTS | Retirement notice valid per port |
| ret_areg_i | input | RET_PORTS*AREG_W | Register written by the retiring entry |
| ret_tag_i | input | RET_PORTS*TAG_W | ROB entry number that retires |
| grp_fire_o | output | 1 | Group accepted this cycle |
| grp_stall_o | output | 1 | Group held back for lack of ROB entries |
| dst_tag_o | output | GROUP*TAG_W | Destination ROB tag per slot |
| srca_rob_o | output | GROUP | First source lives in the ROB (1) or the RRF (0) |
| srca_tag_o | output | GROUP*TAG_W | First source ROB tag |
| srcb_rob_o | output | GROUP | Second source lives in the ROB (1) or the RRF (0) |
| srcb_tag_o | output | GROUP*TAG_W | Second source ROB tag |

## Verification
The interesting collision is a retirement and a rename of the same register in the same cycle. In that cycle a source may read a mapping that is being cleared, and a destination may overwrite it. The bench sets this up in directed steps. It retires a register's live tag while a slot reads that register and a later slot writes it. It then reads the register back in the next group, which must see the new tag and not the RRF. Random cycles set half of their retirement tags to the register's current mapping so that such overlaps recur. The bench judges every source against a model that applies the retirement to the pre-cycle table before forwarding within the group.

// File: rtl/rat_pkg.sv
package rat_pkg;
  // Default geometry of the renamer
  localparam int unsigned RAT_ARCH_REGS = 16;
  localparam int unsigned RAT_ROB_DEPTH = 32;  // power of two: tags wrap naturally
  localparam int unsigned RAT_GROUP     = 4;
  localparam int unsigned RAT_RET_PORTS = 2;
endpackage

// File: rtl/rat_alloc.sv
// Destination tag assignment and group admission.
module rat_alloc #(
  parameter int unsigned GROUP  = 4,
  parameter int unsigned TAG_W  = 5,
  parameter int unsigned FREE_W = 6
) (
  input  logic                        flush_i,
  input  logic [GROUP-1:0]            slot_vld_i,
  input  logic [GROUP-1:0]            slot_wr_i,
  input  logic [TAG_W-1:0]            tail_i,
  input  logic [FREE_W-1:0]           free_i,
  output logic [GROUP-1:0][TAG_W-1:0] dtag_o,
  output logic                        fire_o,
  output logic                        stall_o
);
  localparam int unsigned CNT_W = $clog2(GROUP + 1);

  logic [CNT_W-1:0] need;
  logic             any_vld;

  // Running count of older writers gives each slot its offset from the tail
  always_comb begin
    need = '0;
    for (int g = 0; g < GROUP; g++) begin
      dtag_o[g] = tail_i + TAG_W'(need);
      if (slot_vld_i[g] && slot_wr_i[g]) need = need + 1'b1;
    end
  end

  assign any_vld = |slot_vld_i;
  assign stall_o = any_vld && !flush_i && (FREE_W'(need) > free_i);
  assign fire_o  = any_vld && !flush_i && !stall_o;
endmodule

// File: rtl/rat_table.sv
// Mapping storage: per-register ROB flag and tag, retire clear, group write.
module rat_table #(
  parameter int unsigned AREGS  = 16,
  parameter int unsigned GROUP  = 4,
  parameter int unsigned RETP   = 2,
  parameter int unsigned TAG_W  = 5,
  parameter int unsigned AREG_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_i,
  input  logic                        fire_i,
  input  logic [GROUP-1:0]            wr_eff_i,
  input  logic [GROUP-1:0][AREG_W-1:0] dst_i,
  input  logic [GROUP-1:0][TAG_W-1:0] dtag_i,
  input  logic [RETP-1:0]             ret_vld_i,
  input  logic [RETP-1:0][AREG_W-1:0] ret_areg_i,
  input  logic [RETP-1:0][TAG_W-1:0]  ret_tag_i,
  output logic [AREGS-1:0]            view_rob_o,
  output logic [AREGS-1:0][TAG_W-1:0] view_tag_o
);
  logic [AREGS-1:0]            rob_q, rob_d, wr_hit;
  logic [AREGS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic                        upd_en;

  // Read view: stored mapping with this cycle's matching retirements removed
  always_comb begin
    for (int r = 0; r < AREGS; r++) begin
      view_rob_o[r] = rob_q[r];
      for (int p = 0; p < RETP; p++) begin
        if (ret_vld_i[p] && (ret_areg_i[p] == AREG_W'(r)) &&
            rob_q[r] && (tag_q[r] == ret_tag_i[p]))
          view_rob_o[r] = 1'b0;
      end
    end
  end
  assign view_tag_o = tag_q;

  // Next state: retire view, then group writes oldest to youngest, flush last
  always_comb begin
    rob_d  = view_rob_o;
    tag_d  = tag_q;
    wr_hit = '0;
    for (int r = 0; r < AREGS; r++) begin
      for (int g = 0; g < GROUP; g++) begin
        if (fire_i && wr_eff_i[g] && (dst_i[g] == AREG_W'(r))) begin
          rob_d[r]  = 1'b1;
          tag_d[r]  = dtag_i[g];
          wr_hit[r] = 1'b1;
        end
      end
    end
    if (flush_i) rob_d = '0;
  end

  assign upd_en = flush_i | fire_i | (|ret_vld_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rob_q <= '0;
      tag_q <= '0;
    end else if (upd_en) begin
      rob_q <= rob_d;
      tag_q <= tag_d;
    end
  end

  // R9: flush empties every ROB pointer
  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (rob_q == '0));

  // R8: with no rename, retire or flush the table holds still
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !fire_i && (ret_vld_i == '0)) |=> ($stable(rob_q) && $stable(tag_q)));

  // R6: a retirement of the live mapping reverts the register to the RRF
  p_retire_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld_i[0] && !flush_i && rob_q[ret_areg_i[0]] &&
     (tag_q[ret_areg_i[0]] == ret_tag_i[0]) && !wr_hit[ret_areg_i[0]])
    |=> !rob_q[$past(ret_areg_i[0])]);

  // R6: a retirement of a stale tag leaves the mapping alone
  p_retire_stale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_vld_i == RETP'(1)) && !flush_i && !fire_i && rob_q[ret_areg_i[0]] &&
     (tag_q[ret_areg_i[0]] != ret_tag_i[0]))
    |=> (rob_q[$past(ret_areg_i[0])] &&
         (tag_q[$past(ret_areg_i[0])] == $past(tag_q[ret_areg_i[0]]))));
endmodule

// File: rtl/rat_src_resolve.sv
// One source operand: table view, overridden by the youngest older writer in the group.
module rat_src_resolve #(
  parameter int unsigned AREGS  = 16,
  parameter int unsigned GROUP  = 4,
  parameter int unsigned TAG_W  = 5,
  parameter int unsigned AREG_W = 4,
  parameter int unsigned SLOT   = 0
) (
  input  logic [AREGS-1:0]             view_rob_i,
  input  logic [AREGS-1:0][TAG_W-1:0]  view_tag_i,
  input  logic [GROUP-1:0]             wr_eff_i,
  input  logic [GROUP-1:0][AREG_W-1:0] dst_i,
  input  logic [GROUP-1:0][TAG_W-1:0]  dtag_i,
  input  logic [AREG_W-1:0]            src_i,
  output logic                         rob_o,
  output logic [TAG_W-1:0]             tag_o
);
  always_comb begin
    rob_o = view_rob_i[src_i];
    tag_o = view_tag_i[src_i];
    for (int j = 0; j < GROUP; j++) begin
      if ((j < int'(SLOT)) && wr_eff_i[j] && (dst_i[j] == src_i)) begin
        rob_o = 1'b1;
        tag_o = dtag_i[j];
      end
    end
  end
endmodule

// File: rtl/rat_renamer.sv
module rat_renamer
  import rat_pkg::*;
#(
  parameter int unsigned AREGS     = RAT_ARCH_REGS,
  parameter int unsigned ROB_DEPTH = RAT_ROB_DEPTH,
  parameter int unsigned GROUP     = RAT_GROUP,
  parameter int unsigned RET_PORTS = RAT_RET_PORTS,
  localparam int unsigned AREG_W   = $clog2(AREGS),
  localparam int unsigned TAG_W    = $clog2(ROB_DEPTH),
  localparam int unsigned FREE_W   = $clog2(ROB_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_i,
  input  logic [GROUP-1:0]            slot_vld_i,
  input  logic [GROUP-1:0]            slot_wr_i,
  input  logic [GROUP*AREG_W-1:0]     slot_dst_i,
  input  logic [GROUP*AREG_W-1:0]     slot_srca_i,
  input  logic [GROUP*AREG_W-1:0]     slot_srcb_i,
  input  logic [TAG_W-1:0]            rob_tail_i,
  input  logic [FREE_W-1:0]           rob_free_i,
  input  logic [RET_PORTS-1:0]        ret_vld_i,
  input  logic [RET_PORTS*AREG_W-1:0] ret_areg_i,
  input  logic [RET_PORTS*TAG_W-1:0]  ret_tag_i,
  output logic                        grp_fire_o,
  output logic                        grp_stall_o,
  output logic [GROUP*TAG_W-1:0]      dst_tag_o,
  output logic [GROUP-1:0]            srca_rob_o,
  output logic [GROUP*TAG_W-1:0]      srca_tag_o,
  output logic [GROUP-1:0]            srcb_rob_o,
  output logic [GROUP*TAG_W-1:0]      srcb_tag_o
);
  // Reset: asserted asynchronously, released through two flops
  logic rst_q1, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_q1  <= 1'b1;
      rst_n_s <= rst_q1;
    end
  end

  logic [GROUP-1:0][AREG_W-1:0]     dst_a, srca_a, srcb_a;
  logic [GROUP-1:0][TAG_W-1:0]      dtag_a, srca_tag_a, srcb_tag_a;
  logic [RET_PORTS-1:0][AREG_W-1:0] ret_areg_a;
  logic [RET_PORTS-1:0][TAG_W-1:0]  ret_tag_a;
  logic [GROUP-1:0]                 wr_eff;
  logic [AREGS-1:0]                 view_rob;
  logic [AREGS-1:0][TAG_W-1:0]      view_tag;
  logic                             fire;

  assign dst_a      = slot_dst_i;
  assign srca_a     = slot_srca_i;
  assign srcb_a     = slot_srcb_i;
  assign ret_areg_a = ret_areg_i;
  assign ret_tag_a  = ret_tag_i;
  assign wr_eff     = slot_vld_i & slot_wr_i;

  rat_alloc #(.GROUP(GROUP), .TAG_W(TAG_W), .FREE_W(FREE_W)) u_alloc (
    .flush_i    (flush_i),
    .slot_vld_i (slot_vld_i),
    .slot_wr_i  (slot_wr_i),
    .tail_i     (rob_tail_i),
    .free_i     (rob_free_i),
    .dtag_o     (dtag_a),
    .fire_o     (fire),
    .stall_o    (grp_stall_o)
  );

  rat_table #(.AREGS(AREGS), .GROUP(GROUP), .RETP(RET_PORTS),
              .TAG_W(TAG_W), .AREG_W(AREG_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .flush_i    (flush_i),
    .fire_i     (fire),
    .wr_eff_i   (wr_eff),
    .dst_i      (dst_a),
    .dtag_i     (dtag_a),
    .ret_vld_i  (ret_vld_i),
    .ret_areg_i (ret_areg_a),
    .ret_tag_i  (ret_tag_a),
    .view_rob_o (view_rob),
    .view_tag_o (view_tag)
  );

  for (genvar g = 0; g < GROUP; g++) begin : g_slot
    rat_src_resolve #(.AREGS(AREGS), .GROUP(GROUP), .TAG_W(TAG_W),
                      .AREG_W(AREG_W), .SLOT(g)) u_srca (
      .view_rob_i (view_rob),
      .view_tag_i (view_tag),
      .wr_eff_i   (wr_eff),
      .dst_i      (dst_a),
      .dtag_i     (dtag_a),
      .src_i      (srca_a[g]),
      .rob_o      (srca_rob_o[g]),
      .tag_o      (srca_tag_a[g])
    );
    rat_src_resolve #(.AREGS(AREGS), .GROUP(GROUP), .TAG_W(TAG_W),
                      .AREG_W(AREG_W), .SLOT(g)) u_srcb (
      .view_rob_i (view_rob),
      .view_tag_i (view_tag),
      .wr_eff_i   (wr_eff),
      .dst_i      (dst_a),
      .dtag_i     (dtag_a),
      .src_i      (srcb_a[g]),
      .rob_o      (srcb_rob_o[g]),
      .tag_o      (srcb_tag_a[g])
    );
  end

  assign grp_fire_o = fire;
  assign dst_tag_o  = dtag_a;
  assign srca_tag_o = srca_tag_a;
  assign srcb_tag_o = srcb_tag_a;

  for (genvar g = 1; g < GROUP; g++) begin : g_chk
    // R2: neighbouring writers receive consecutive ROB tags
    p_tag_seq_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
      (wr_eff[g] && wr_eff[g-1]) |-> (dtag_a[g] == dtag_a[g-1] + 1'b1));

    // R4: a source naming the previous slot's destination takes its new tag
    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
      (slot_vld_i[g] && wr_eff[g-1] && (srca_a[g] == dst_a[g-1]))
      |-> (srca_rob_o[g] && (srca_tag_a[g] == dtag_a[g-1])));
  end

  // R8: an accepted group never needs more entries than are free
  p_fire_fits_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    grp_fire_o |-> ($countones(wr_eff) <= int'(rob_free_i)));
endmodule

// File: tb/rat_renamer_test.sv
`timescale 1ns/1ps
module rat_renamer_test;
  localparam int G = 4;
  localparam int AW = 4;
  localparam int TW = 5;
  localparam int FW = 6;
  localparam int NR = 16;
  localparam int RP = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic flush_i;
  logic [G-1:0] slot_vld_i, slot_wr_i;
  logic [G*AW-1:0] slot_dst_i, slot_srca_i, slot_srcb_i;
  logic [TW-1:0] rob_tail_i;
  logic [FW-1:0] rob_free_i;
  logic [RP-1:0] ret_vld_i;
  logic [RP*AW-1:0] ret_areg_i;
  logic [RP*TW-1:0] ret_tag_i;
  logic grp_fire_o, grp_stall_o;
  logic [G*TW-1:0] dst_tag_o, srca_tag_o, srcb_tag_o;
  logic [G-1:0] srca_rob_o, srcb_rob_o;

  always #2 clk = ~clk;

  rat_renamer uut (.*);

  // Stimulus variables
  bit         s_vld[G], s_wr[G], s_fl;
  logic [3:0] s_dst[G], s_sa[G], s_sb[G];
  logic [4:0] s_tail;
  logic [5:0] s_free;
  bit         s_rv[RP];
  logic [3:0] s_ra[RP];
  logic [4:0] s_rt[RP];

  // Reference mapping
  bit         m_rob[NR];
  logic [4:0] m_tag[NR];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    for (int g = 0; g < G; g++) begin
      s_vld[g] = 0; s_wr[g] = 0; s_dst[g] = 0; s_sa[g] = 0; s_sb[g] = 0;
    end
    for (int p = 0; p < RP; p++) begin
      s_rv[p] = 0; s_ra[p] = 0; s_rt[p] = 0;
    end
    s_fl = 0; s_tail = 0; s_free = 6'd32;
  endtask

  // One cycle: drive at the falling edge, check the combinational outputs, update the model
  task automatic run(input string lbl);
    bit         erob[NR];
    logic [4:0] etag[NR];
    bit         retd[NR];
    logic [4:0] e_dt[G];
    int         need;
    bit         any_v, e_stall, e_fire;
    @(negedge clk);
    for (int g = 0; g < G; g++) begin
      slot_vld_i[g] = s_vld[g];
      slot_wr_i[g]  = s_wr[g];
      slot_dst_i[g*AW +: AW]  = s_dst[g];
      slot_srca_i[g*AW +: AW] = s_sa[g];
      slot_srcb_i[g*AW +: AW] = s_sb[g];
    end
    for (int p = 0; p < RP; p++) begin
      ret_vld_i[p] = s_rv[p];
      ret_areg_i[p*AW +: AW] = s_ra[p];
      ret_tag_i[p*TW +: TW]  = s_rt[p];
    end
    flush_i = s_fl; rob_tail_i = s_tail; rob_free_i = s_free;
    #1;
    for (int r = 0; r < NR; r++) begin
      erob[r] = m_rob[r]; etag[r] = m_tag[r]; retd[r] = 0;
    end
    for (int p = 0; p < RP; p++)
      if (s_rv[p] && m_rob[s_ra[p]] && m_tag[s_ra[p]] == s_rt[p]) begin
        erob[s_ra[p]] = 0; retd[s_ra[p]] = 1;
      end
    need = 0; any_v = 0;
    for (int g = 0; g < G; g++) begin
      e_dt[g] = s_tail + 5'(need);
      if (s_vld[g] && s_wr[g]) need++;
      any_v |= s_vld[g];
    end
    e_stall = any_v && !s_fl && (need > int'(s_free));
    e_fire  = any_v && !s_fl && !e_stall;
    chk(s_fl ? "R9" : "R8", "fire", 32'(grp_fire_o), 32'(e_fire));
    chk("R8", "stall", 32'(grp_stall_o), 32'(e_stall));
    for (int g = 0; g < G; g++) begin
      if (s_vld[g] && s_wr[g])
        chk("R2", $sformatf("dst tag slot %0d", g), 32'(dst_tag_o[g*TW +: TW]), 32'(e_dt[g]));
      if (s_vld[g]) begin
        for (int k = 0; k < 2; k++) begin
          logic [3:0] src;
          bit         xrob;
          logic [4:0] xtag;
          string      l;
          logic       arob;
          logic [4:0] atag;
          src  = (k == 0) ? s_sa[g] : s_sb[g];
          xrob = erob[src]; xtag = etag[src];
          l    = retd[src] ? "R7" : "R3";
          for (int j = 0; j < g; j++)
            if (s_vld[j] && s_wr[j] && s_dst[j] == src) begin
              xrob = 1; xtag = e_dt[j]; l = "R4";
            end
          if (lbl != "") l = lbl;
          arob = (k == 0) ? srca_rob_o[g] : srcb_rob_o[g];
          atag = (k == 0) ? srca_tag_o[g*TW +: TW] : srcb_tag_o[g*TW +: TW];
          chk(l, $sformatf("slot %0d src%0d r%0d in-rob", g, k, src), 32'(arob), 32'(xrob));
          if (xrob)
            chk(l, $sformatf("slot %0d src%0d r%0d tag", g, k, src), 32'(atag), 32'(xtag));
        end
      end
    end
    @(posedge clk);
    if (s_fl) begin
      for (int r = 0; r < NR; r++) m_rob[r] = 0;
    end else begin
      for (int r = 0; r < NR; r++) if (retd[r]) m_rob[r] = 0;
      if (e_fire)
        for (int g = 0; g < G; g++)
          if (s_vld[g] && s_wr[g]) begin
            m_rob[s_dst[g]] = 1; m_tag[s_dst[g]] = e_dt[g];
          end
    end
  endtask

  task automatic read_regs(input logic [3:0] a, input logic [3:0] b, input string lbl);
    idle();
    s_vld[0] = 1; s_sa[0] = a; s_sb[0] = b;
    run(lbl);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int r = 0; r < NR; r++) begin m_rob[r] = 0; m_tag[r] = 0; end
    idle();
    rst_n = 1'b0;
    slot_vld_i = '0; slot_wr_i = '0; slot_dst_i = '0; slot_srca_i = '0; slot_srcb_i = '0;
    rob_tail_i = '0; rob_free_i = '0; ret_vld_i = '0; ret_areg_i = '0; ret_tag_i = '0;
    flush_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: every register on the RRF after reset
    for (int c = 0; c < 2; c++) begin
      idle();
      for (int g = 0; g < G; g++) begin
        s_vld[g] = 1; s_sa[g] = 4'(c*8 + g*2); s_sb[g] = 4'(c*8 + g*2 + 1);
      end
      run("R1");
    end

    // R2/R4: tags wrap from 30, slot 1 has no destination, repeated writer
    idle();
    s_tail = 5'd30;
    s_vld[0] = 1; s_wr[0] = 1; s_dst[0] = 3; s_sa[0] = 3;
    s_vld[1] = 1; s_sa[1] = 3;
    s_vld[2] = 1; s_wr[2] = 1; s_dst[2] = 3; s_sa[2] = 3;
    s_vld[3] = 1; s_wr[3] = 1; s_dst[3] = 5; s_sa[3] = 3; s_sb[3] = 5;
    run("");
    // R5: youngest writer of r3 (tag 31) kept
    read_regs(3, 5, "R5");

    // R6: stale retirement ignored, live one reverts
    idle(); s_rv[0] = 1; s_ra[0] = 3; s_rt[0] = 5'd30; run("");
    read_regs(3, 3, "R6");
    idle(); s_rv[1] = 1; s_ra[1] = 3; s_rt[1] = 5'd31; run("");
    read_regs(3, 5, "R6");

    // R7: retirement of r5 seen by same-cycle reader; same-cycle rename of r5 wins
    idle();
    s_rv[0] = 1; s_ra[0] = 5; s_rt[0] = 5'd0; s_tail = 5'd7;
    s_vld[0] = 1; s_sa[0] = 5; s_sb[0] = 3;
    s_vld[1] = 1; s_wr[1] = 1; s_dst[1] = 5;
    s_vld[2] = 1; s_sa[2] = 5;
    run("");
    read_regs(5, 5, "R7");

    // R8: two destinations, one free entry: whole group held
    idle();
    s_free = 6'd1; s_tail = 5'd10;
    s_vld[0] = 1; s_wr[0] = 1; s_dst[0] = 1;
    s_vld[1] = 1; s_wr[1] = 1; s_dst[1] = 2;
    run("");
    read_regs(1, 2, "R8");

    // R10: invalid slot with a destination changes nothing
    idle();
    s_tail = 5'd12;
    s_vld[0] = 0; s_wr[0] = 1; s_dst[0] = 4;
    s_vld[1] = 1; s_wr[1] = 1; s_dst[1] = 6;
    run("");
    read_regs(4, 6, "R10");

    // R9: flush blocks the group and clears every mapping
    idle();
    s_fl = 1; s_vld[0] = 1; s_wr[0] = 1; s_dst[0] = 8;
    run("");
    read_regs(5, 6, "R9");
    read_regs(8, 3, "R9");

    // Random traffic
    for (int c = 0; c < 3000; c++) begin
      int m;
      idle();
      m = ($urandom % 2 == 0) ? 8 : 16;
      for (int g = 0; g < G; g++) begin
        s_vld[g] = ($urandom % 4) != 0;
        s_wr[g]  = ($urandom % 3) != 0;
        s_dst[g] = 4'($urandom % m);
        s_sa[g]  = 4'($urandom % m);
        s_sb[g]  = 4'($urandom % m);
      end
      for (int p = 0; p < RP; p++) begin
        s_rv[p] = ($urandom % 2) == 0;
        s_ra[p] = 4'($urandom % m);
        s_rt[p] = ($urandom % 2 == 0) ? m_tag[s_ra[p]] : 5'($urandom);
      end
      s_tail = 5'($urandom);
      s_free = 6'($urandom % 9);
      s_fl   = ($urandom % 40) == 0;
      run("");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule